// File: doc/BRIEF.md
# Line-Based Frame Read Sequencer

This block is the initiating side of a simple burst-read link that pulls a complete image frame out of a pixel source, one line at a time. It waits for a frame-ready interrupt from the sensor side. It then reads every line as its own burst, using a start and a ready handshake with active-low signals. Each beat the target supplies is forwarded to a memory-side pixel sink as a write strobe with data.

The pixels per line and the lines per frame are inputs that can be changed at run time. They are captured when a frame starts. Every line costs a fixed overhead of `OVH` clocks (15 by default) on top of one clock per beat. That overhead is made of a one-cycle address phase before the burst and `OVH-1` idle clocks after it. With a target that never inserts wait states, a line takes `beats+15` clocks. At the usual 640 by 480 geometry a frame therefore takes 655 × 480 = 314400 clocks.

After the last beat of the last line, the block pulses a done flag. It then runs the final gap. At the end of that gap it either goes idle or, if the interrupt is still raised, starts the next frame at once.

Top module: `frs_frame_seq`

## Requirements
- R1: While `rst` is high and in the cycle after it, `frame_n` and `irdy_n` are 1, `wr_en` is 0, `frame_done` is 0 and `line_count` is 0.
- R2: When idle, no address cycle is issued while `frame_irq` is 0. No address cycle is issued when `cfg_beats` or `cfg_lines` is 0, even if `frame_irq` is 1.
- R3: Each line starts with exactly one address cycle (`frame_n`=0, `irdy_n`=1). From the next cycle, `irdy_n` is 0 for the whole data phase.
- R4: A beat is accepted only in a cycle where `irdy_n` is 0 and `trdy_n` is sampled 0. In that cycle `wr_en` is 1 and `wr_data` equals `data_in`. While `trdy_n` stays 1, the block waits with no limit and accepts nothing.
- R5: During the data phase, `frame_n` is 0 while a beat other than the last is pending. It is 1 in every cycle in which the last beat of the line is pending, including that beat's wait cycles.
- R6: `irdy_n` returns to 1 in the cycle after the last beat of a line is accepted.
- R7: After each burst, `frame_n` and `irdy_n` stay 1 for `OVH-1` = 14 cycles. The next line's address cycle then follows by itself. With no wait states, consecutive address cycles are `cfg_beats+15` clocks apart.
- R8: `line_count` rises by exactly one at the clock edge that accepts a line's last beat. It is cleared to 0 when a new frame starts.
- R9: `frame_done` is a one-cycle pulse in the cycle right after the last beat of the last line. After that line's gap, the block goes idle if `frame_irq` is 0, or starts a new frame directly if it is 1.
- R10: The geometry is captured at frame start. Changing `cfg_beats` or `cfg_lines` during a frame does not change the number of beats or lines in that frame.
- R11: With a target that has no wait states and `frame_irq` held high, consecutive frame starts are `lines*(beats+15)` clocks apart. At the default 640 by 480 geometry this is 314400 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_irq | input | 1 | Frame-ready interrupt from the sensor side |
| cfg_beats | input | BEAT_W | Beats (pixels) per line; captured at frame start |
| cfg_lines | input | LINE_W | Lines per frame; captured at frame start |
| trdy_n | input | 1 | Target ready, active low |
| data_in | input | DATA_W | Pixel data from the target |
| frame_n | output | 1 | Burst-in-progress strobe, active low; released before the last beat |
| irdy_n | output | 1 | Initiator ready, active low, during the data phase |
| wr_en | output | 1 | Write strobe toward the pixel sink, one per accepted beat |
| wr_data | output | DATA_W | Pixel value written with `wr_en` |
| frame_done | output | 1 | One-cycle pulse after the last beat of the frame |
| line_count | output | LINE_W | Lines completed in the current frame |

## Verification
Three situations are hard to reach from the ports. The first is the last beat of a line meeting target wait states, where `frame_n` must already be released while `irdy_n` is still held. The bench reaches it with a pseudo-random `trdy_n` pattern on short lines and with a one-beat line. The second is the direct restart after the last gap when `frame_irq` is still high. The bench reaches it by holding the interrupt through a long 640-beat frame and timing the distance between the two frame-start address cycles. The third is a geometry change in mid-frame; the bench covers it by rewriting both configuration inputs a few cycles into a frame and counting the write strobes.

// File: rtl/frs_pkg.sv
package frs_pkg;

    localparam int DEF_BEATS = 640;
    localparam int DEF_LINES = 480;
    localparam int DEF_OVH   = 15;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } frs_state_e;

    typedef struct packed {
        logic start;
        logic beat_clr;
        logic beat_inc;
        logic line_clr;
        logic line_inc;
        logic gap_clr;
        logic gap_inc;
        logic done_set;
    } frs_ctl_t;

endpackage

// File: rtl/frs_counter.sv
module frs_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
    import frs_pkg::*;
#(
    parameter int BEAT_W = 16,
    parameter int LINE_W = 16,
    parameter int OVH    = 15,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_irq,
    input  logic              cfg_ok,
    input  logic              trdy_n,
    input  logic [BEAT_W-1:0] beat_cnt,
    input  logic [BEAT_W-1:0] beats_q,
    input  logic [LINE_W-1:0] line_cnt,
    input  logic [LINE_W-1:0] lines_q,
    input  logic [GAP_W-1:0]  gap_cnt,
    output frs_state_e        state,
    output frs_ctl_t          ctl,
    output logic              last_beat
);

    frs_state_e nxt;
    logic       accept;
    logic       gap_end;
    logic       last_line;
    logic       frame_over;

    assign last_beat  = (beat_cnt == (beats_q - 1'b1));
    assign last_line  = ((line_cnt + 1'b1) == lines_q);
    assign frame_over = (line_cnt == lines_q);
    assign gap_end    = (gap_cnt == GAP_W'(OVH - 2));
    assign accept     = (state == ST_DATA) && !trdy_n;

    always_comb begin
        nxt = state;
        ctl = '0;
        case (state)
            ST_IDLE: begin
                if (frame_irq && cfg_ok) begin
                    ctl.start    = 1'b1;
                    ctl.line_clr = 1'b1;
                    nxt          = ST_ADDR;
                end
            end
            ST_ADDR: begin
                ctl.beat_clr = 1'b1;
                nxt          = ST_DATA;
            end
            ST_DATA: begin
                if (accept) begin
                    ctl.beat_inc = 1'b1;
                    if (last_beat) begin
                        ctl.line_inc = 1'b1;
                        ctl.gap_clr  = 1'b1;
                        ctl.done_set = last_line;
                        nxt          = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                ctl.gap_inc = 1'b1;
                if (gap_end) begin
                    if (!frame_over) begin
                        nxt = ST_ADDR;
                    end else if (frame_irq && cfg_ok) begin
                        ctl.start    = 1'b1;
                        ctl.line_clr = 1'b1;
                        nxt          = ST_ADDR;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/frs_frame_seq.sv
module frs_frame_seq
    import frs_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int BEAT_W = 16,
    parameter int LINE_W = 16,
    parameter int OVH    = DEF_OVH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_irq,
    input  logic [BEAT_W-1:0] cfg_beats,
    input  logic [LINE_W-1:0] cfg_lines,
    input  logic              trdy_n,
    input  logic [DATA_W-1:0] data_in,
    output logic              frame_n,
    output logic              irdy_n,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              frame_done,
    output logic [LINE_W-1:0] line_count
);

    localparam int GAP_W = (OVH > 2) ? $clog2(OVH) : 1;

    frs_state_e        state;
    frs_ctl_t          ctl;
    logic              last_beat;
    logic              cfg_ok;
    logic [BEAT_W-1:0] beats_q;
    logic [LINE_W-1:0] lines_q;
    logic [BEAT_W-1:0] beat_cnt;
    logic [LINE_W-1:0] line_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic              done_q;

    assign cfg_ok = (cfg_beats != '0) && (cfg_lines != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            beats_q <= '0;
            lines_q <= '0;
        end else if (ctl.start) begin
            beats_q <= cfg_beats;
            lines_q <= cfg_lines;
        end
    end

    frs_ctrl #(
        .BEAT_W(BEAT_W),
        .LINE_W(LINE_W),
        .OVH   (OVH),
        .GAP_W (GAP_W)
    ) i_ctrl (
        .clk      (clk),
        .rst      (rst),
        .frame_irq(frame_irq),
        .cfg_ok   (cfg_ok),
        .trdy_n   (trdy_n),
        .beat_cnt (beat_cnt),
        .beats_q  (beats_q),
        .line_cnt (line_cnt),
        .lines_q  (lines_q),
        .gap_cnt  (gap_cnt),
        .state    (state),
        .ctl      (ctl),
        .last_beat(last_beat)
    );

    frs_counter #(.W(BEAT_W)) i_beat_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.beat_clr),
        .inc  (ctl.beat_inc),
        .count(beat_cnt)
    );

    frs_counter #(.W(LINE_W)) i_line_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.line_clr),
        .inc  (ctl.line_inc),
        .count(line_cnt)
    );

    frs_counter #(.W(GAP_W)) i_gap_ctr (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.gap_clr),
        .inc  (ctl.gap_inc),
        .count(gap_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= ctl.done_set;
        end
    end

    assign frame_n    = !((state == ST_ADDR) || ((state == ST_DATA) && !last_beat));
    assign irdy_n     = !(state == ST_DATA);
    assign wr_en      = (state == ST_DATA) && !trdy_n;
    assign wr_data    = data_in;
    assign frame_done = done_q;
    assign line_count = line_cnt;

endmodule

// File: rtl/frs_frame_seq_chk.sv
module frs_frame_seq_chk #(
    parameter int DATA_W = 10,
    parameter int LINE_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              trdy_n,
    input logic              frame_n,
    input logic              irdy_n,
    input logic              wr_en,
    input logic              frame_done,
    input logic [LINE_W-1:0] line_count
);

    AST_ADDR_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
        (!frame_n && irdy_n) |=> !irdy_n); // R3

    AST_WR_NEEDS_HS: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (!irdy_n && !trdy_n)); // R4

    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!irdy_n && trdy_n) |=> !irdy_n); // R4

    AST_LAST_STAYS_OPEN: assert property (@(posedge clk) disable iff (rst)
        (!irdy_n && frame_n) |=> frame_n); // R5

    AST_IRDY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!irdy_n && frame_n && !trdy_n) |=> irdy_n); // R6

    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (rst)
        $rose(irdy_n) |-> frame_n); // R7

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(line_count) |-> ((line_count == $past(line_count) + 1'b1) || (line_count == '0))); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done); // R9

    AST_DONE_AFTER_BEAT: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> $past(wr_en)); // R9

endmodule

bind frs_frame_seq frs_frame_seq_chk #(
    .DATA_W(DATA_W),
    .LINE_W(LINE_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .trdy_n    (trdy_n),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .wr_en     (wr_en),
    .frame_done(frame_done),
    .line_count(line_count)
);

// File: tb/test_frs_frame_seq.sv
module test_frs_frame_seq;

    localparam int DW  = 10;
    localparam int BW  = 16;
    localparam int LW  = 16;
    localparam int OVH = 15;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_irq = 1'b0;
    logic [BW-1:0] cfg_beats = '0;
    logic [LW-1:0] cfg_lines = '0;
    logic          trdy_n = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          frame_n, irdy_n, wr_en, frame_done;
    logic [DW-1:0] wr_data;
    logic [LW-1:0] line_count;

    frs_frame_seq #(.DATA_W(DW), .BEAT_W(BW), .LINE_W(LW), .OVH(OVH)) i_frs_frame_seq (
        .clk(clk), .rst(rst), .frame_irq(frame_irq), .cfg_beats(cfg_beats),
        .cfg_lines(cfg_lines), .trdy_n(trdy_n), .data_in(data_in),
        .frame_n(frame_n), .irdy_n(irdy_n), .wr_en(wr_en), .wr_data(wr_data),
        .frame_done(frame_done), .line_count(line_count)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    int tr_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    int wr_cnt = 0;
    int ls_q[$];
    int fs_q[$];

    // behavioural reference state
    int m_mode = 0;
    int m_beat = 0;
    int m_line = 0;
    int m_gap  = 0;
    int m_lb   = 0;
    int m_ll   = 0;
    bit m_done = 0;

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // stimulus for target side, changed 2 ns after each rising edge
    always @(posedge clk) begin
        #2;
        data_in <= data_in + 1'b1;
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (tr_mode)
            0:       trdy_n <= 1'b0;
            1:       trdy_n <= lfsr[0] & lfsr[3];
            default: trdy_n <= 1'b1;
        endcase
    end

    // reference model advance
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_mode = 0; m_beat = 0; m_line = 0; m_gap = 0; m_done = 0;
            m_lb = 0; m_ll = 0;
        end else begin
            m_done = 0;
            case (m_mode)
                0: if (frame_irq && cfg_beats != 0 && cfg_lines != 0) begin
                    m_lb = int'(cfg_beats); m_ll = int'(cfg_lines); m_line = 0; m_mode = 1;
                end
                1: begin m_beat = 0; m_mode = 2; end
                2: if (!trdy_n) begin
                    m_beat++;
                    if (m_beat == m_lb) begin
                        m_line++; m_gap = 0; m_mode = 3;
                        if (m_line == m_ll) m_done = 1;
                    end
                end
                default: begin
                    m_gap++;
                    if (m_gap == OVH - 1) begin
                        if (m_line < m_ll) m_mode = 1;
                        else if (frame_irq && cfg_beats != 0 && cfg_lines != 0) begin
                            m_lb = int'(cfg_beats); m_ll = int'(cfg_lines); m_line = 0; m_mode = 1;
                        end else m_mode = 0;
                    end
                end
            endcase
        end
    end

    // per-clock comparison and port monitors
    always @(negedge clk) begin
        check("R5 frame_n", int'(frame_n), (m_mode == 1 || (m_mode == 2 && m_beat != m_lb - 1)) ? 0 : 1);
        check("R6 irdy_n", int'(irdy_n), (m_mode == 2) ? 0 : 1);
        check("R4 wr_en", int'(wr_en), (m_mode == 2 && !trdy_n) ? 1 : 0);
        check("R9 frame_done", int'(frame_done), int'(m_done));
        check("R8 line_count", int'(line_count), m_line);
        if (wr_en) begin
            check("R4 wr_data", int'(wr_data), int'(data_in));
            wr_cnt++;
        end
        if (!frame_n && irdy_n) begin
            ls_q.push_back(cyc);
            if (line_count == 0) fs_q.push_back(cyc);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clear_mon();
        wr_cnt = 0;
        ls_q.delete();
        fs_q.delete();
    endtask

    task automatic wait_done(input string tag, input int lim);
        int k = 0;
        while (k < lim) begin
            @(negedge clk);
            if (frame_done) break;
            k++;
        end
        check({tag, " frame_done seen"}, (k < lim) ? 1 : 0, 1);
        step(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        step(3);
        @(negedge clk);
        check("R1 frame_n", int'(frame_n), 1);
        check("R1 irdy_n", int'(irdy_n), 1);
        check("R1 wr_en", int'(wr_en), 0);
        check("R1 frame_done", int'(frame_done), 0);
        check("R1 line_count", int'(line_count), 0);
        step(1);
        rst = 1'b0;
        step(1);

        // R3 and R7: short frame, no wait states
        clear_mon();
        tr_mode = 0; cfg_beats = 4; cfg_lines = 3;
        frame_irq = 1'b1; step(1); frame_irq = 1'b0;
        wait_done("R3", 500);
        step(OVH + 2);
        check("R3 address cycles", ls_q.size(), 3);
        if (ls_q.size() >= 2) check("R7 line period", ls_q[1] - ls_q[0], 4 + 15);
        check("R4 beats written", wr_cnt, 12);
        check("R8 final line_count", int'(line_count), 3);

        // R10: random waits, geometry rewritten mid-frame
        clear_mon();
        tr_mode = 1; cfg_beats = 5; cfg_lines = 2;
        frame_irq = 1'b1; step(1); frame_irq = 1'b0;
        step(3);
        cfg_beats = 9; cfg_lines = 9;
        wait_done("R10", 2000);
        step(40);
        check("R10 beats in frame", wr_cnt, 10);
        check("R9 idle after frame", ls_q.size(), 2);

        // R5: one-beat lines
        clear_mon();
        tr_mode = 0; cfg_beats = 1; cfg_lines = 2;
        frame_irq = 1'b1; step(1); frame_irq = 1'b0;
        wait_done("R5", 200);
        check("R5 one-beat writes", wr_cnt, 2);
        step(OVH);

        // R4: target stalls indefinitely
        clear_mon();
        tr_mode = 2; cfg_beats = 3; cfg_lines = 1;
        frame_irq = 1'b1; step(1); frame_irq = 1'b0;
        step(60);
        @(negedge clk);
        check("R4 no beat while stalled", wr_cnt, 0);
        check("R4 irdy_n held in stall", int'(irdy_n), 0);
        check("R4 line_count in stall", int'(line_count), 0);
        step(1);
        tr_mode = 0;
        wait_done("R4", 100);
        check("R4 beats after stall", wr_cnt, 3);
        step(OVH + 2);

        // R2: no start without interrupt or with zero geometry
        clear_mon();
        cfg_beats = 4; cfg_lines = 2; frame_irq = 1'b0;
        step(30);
        check("R2 no start without irq", ls_q.size(), 0);
        cfg_beats = 0; frame_irq = 1'b1;
        step(30);
        check("R2 no start zero beats", ls_q.size(), 0);
        cfg_beats = 4; cfg_lines = 0;
        step(30);
        check("R2 no start zero lines", ls_q.size(), 0);
        frame_irq = 1'b0; cfg_lines = 2;
        step(2);

        // R11: long lines, interrupt held, frame-to-frame distance
        clear_mon();
        tr_mode = 0; cfg_beats = 640; cfg_lines = 64;
        frame_irq = 1'b1;
        begin
            int k = 0;
            while (fs_q.size() < 2 && k < 60000) begin step(1); k++; end
        end
        check("R11 two frame starts", fs_q.size(), 2);
        if (fs_q.size() >= 2) check("R11 frame period", fs_q[1] - fs_q[0], 64 * (640 + 15));
        if (ls_q.size() >= 2) check("R7 long line period", ls_q[1] - ls_q[0], 655);
        frame_irq = 1'b0;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(2);

        summary();
        $finish;
    end

endmodule